// File: doc/BRIEF.md
# Soft-Decision Add-Compare-Select Trellis Core

This block is the recursive heart of a rate-1/2, constraint-length-7 soft-decision Viterbi decoder. Each clock it can take one pair of 4-bit soft symbols. It turns them into four branch metrics, one for each possible pair of coded bits, and registers those. It then runs add-compare-select for all 64 trellis states as 32 radix-2 butterflies. Each new path metric is renormalized before it is written back. Every step produces a 64-bit survivor decision word and the index of the state that currently has the smallest metric.

A survivor memory and traceback unit, placed downstream, consume the decision word and best state. Those units are not part of this block. An `init` pulse starts a new trellis from state 0 without needing a reset. Because the branch-metric sum sits in its own register stage, only the add, compare, select and renormalize path remains inside the feedback loop.

Top module: `acs_core`

## Requirements
- R1: Soft values are unsigned. 0 means most confident coded bit 0 and 2^SOFT_W-1 (15) means most confident coded bit 1. The distance of a soft value s to expected bit 0 is s, and to expected bit 1 it is 15-s. A branch metric is the sum of the two distances.
- R2: The trellis state is the last six input bits, with the newest bit in bit 0. The encoder word is {state, input}, 7 bits wide. Output A is the parity of that word ANDed with octal 133, and output B is the parity of that word ANDed with octal 171. The next state is the low 6 bits of the encoder word.
- R3: State n has two predecessors: the upper one is n>>1 and the lower one is (n>>1)+32. Each candidate is the predecessor's metric plus its branch metric. The new metric is the smaller candidate. Bit n of `dec_word` is 1 only when the lower candidate is strictly smaller. On a tie the upper predecessor wins and the bit is 0.
- R4: On each step, every new metric has the minimum of the previous step's metrics subtracted from it. Metrics stay within 9 bits without wrapping under any input sequence.
- R5: `best_state` is the lowest-numbered state whose current metric equals the minimum over all states.
- R6: `dec_word` changes only on a cycle where `dec_valid` is high. `best_state` changes only on such a cycle, after `init`, or after reset.
- R7: A symbol pair presented with `in_valid` high at clock edge t gives `dec_valid` high with its results after edge t+1. One step per clock is sustained, and gaps in `in_valid` create gaps in `dec_valid`.
- R8: `init` sets state 0's metric to 0 and every other state's metric to 128 (2^(METRIC_W-2)). A step already in the branch-metric stage at that edge is discarded. A pair presented together with `init` is decoded from the fresh metrics.
- R9: Reset leaves the metrics exactly as `init` does, with `dec_valid` low and `dec_word` all zero.
- R10: With noise-free, full-confidence input following `init`, `best_state` equals the encoder's state after each step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Restart the trellis from state 0 |
| in_valid | input | 1 | Soft pair on soft_a/soft_b is valid |
| soft_a | input | 4 | Soft value for coded output A |
| soft_b | input | 4 | Soft value for coded output B |
| dec_valid | output | 1 | A new step result is present |
| dec_word | output | 64 | Survivor decision bit per state |
| best_state | output | 6 | State with the smallest metric |

## Verification
Four properties are checked on every cycle:
- the two-cycle relation between `in_valid` and `dec_valid`, including the effect of `init`;
- that the outputs hold between steps;
- that `best_state` points at a minimal metric;
- that no metric approaches the 9-bit ceiling.

Some behaviour can only be shown by the scenarios, which compare every decision word and best state against an independent trellis model. This covers the polynomial and bit-order conventions, tie resolution toward the upper predecessor, the renormalized metric values, and tracking of the true encoder state. It also covers a mid-stream `init` that drops an in-flight step.

// File: rtl/acs_pkg.sv
package acs_pkg;
    // Expected coded pair {A,B} for a transition leaving state pred on input bit u.
    function automatic logic [1:0] code_bits(input int unsigned pred, input int unsigned u,
                                             input int unsigned pa, input int unsigned pb);
        int unsigned w;
        w = (pred << 1) | u;
        return {^(w & pa), ^(w & pb)};
    endfunction
endpackage

// File: rtl/acs_bm_unit.sv
module acs_bm_unit #(
    parameter int unsigned SOFT_W = 4
) (
    input  logic [SOFT_W-1:0]    soft_a,
    input  logic [SOFT_W-1:0]    soft_b,
    output logic [3:0][SOFT_W:0] bm
);
    localparam logic [SOFT_W-1:0] SMAX = {SOFT_W{1'b1}};

    logic [SOFT_W-1:0] da0, da1, db0, db1;

    always_comb begin
        da0 = soft_a;
        da1 = SMAX - soft_a;
        db0 = soft_b;
        db1 = SMAX - soft_b;
    end

    for (genvar e = 0; e < 4; e++) begin : g_pair
        localparam bit EA = ((e >> 1) & 1) != 0;
        localparam bit EB = (e & 1) != 0;
        assign bm[e] = {1'b0, (EA ? da1 : da0)} + {1'b0, (EB ? db1 : db0)};
    end
endmodule

// File: rtl/acs_argmin.sv
module acs_argmin #(
    parameter int unsigned NS = 64,
    parameter int unsigned MW = 9,
    localparam int unsigned IW = $clog2(NS)
) (
    input  logic [NS-1:0][MW-1:0] met,
    output logic [MW-1:0]         min_val,
    output logic [IW-1:0]         min_idx
);
    always_comb begin
        min_val = met[0];
        min_idx = '0;
        for (int i = 1; i < NS; i++) begin
            if (met[i] < min_val) begin
                min_val = met[i];
                min_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/acs_bfly.sv
module acs_bfly
    import acs_pkg::*;
#(
    parameter int unsigned J      = 0,
    parameter int unsigned HALF   = 32,
    parameter int unsigned POLY_A = 7'o133,
    parameter int unsigned POLY_B = 7'o171,
    parameter int unsigned BMW    = 5,
    parameter int unsigned MW     = 9
) (
    input  logic [MW-1:0]         m_up,
    input  logic [MW-1:0]         m_lo,
    input  logic [3:0][BMW-1:0]   bm,
    input  logic [MW-1:0]         min_old,
    output logic [1:0][MW-1:0]    m_new,
    output logic [1:0]            dec
);
    for (genvar u = 0; u < 2; u++) begin : g_succ
        localparam logic [1:0] CU = code_bits(J, u, POLY_A, POLY_B);
        localparam logic [1:0] CL = code_bits(J + HALF, u, POLY_A, POLY_B);
        logic [MW-1:0] cand_up, cand_lo, pick;
        always_comb begin
            cand_up  = m_up + MW'(bm[CU]);
            cand_lo  = m_lo + MW'(bm[CL]);
            dec[u]   = cand_lo < cand_up;
            pick     = dec[u] ? cand_lo : cand_up;
            m_new[u] = pick - min_old;
        end
    end
endmodule

// File: rtl/acs_core.sv
module acs_core #(
    parameter int unsigned CONSTR   = 7,
    parameter int unsigned POLY_A   = 7'o133,
    parameter int unsigned POLY_B   = 7'o171,
    parameter int unsigned SOFT_W   = 4,
    parameter int unsigned METRIC_W = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       init,
    input  logic                       in_valid,
    input  logic [SOFT_W-1:0]          soft_a,
    input  logic [SOFT_W-1:0]          soft_b,
    output logic                       dec_valid,
    output logic [(1<<(CONSTR-1))-1:0] dec_word,
    output logic [CONSTR-2:0]          best_state
);
    localparam int unsigned SB       = CONSTR - 1;
    localparam int unsigned NS       = 1 << SB;
    localparam int unsigned HALF     = NS / 2;
    localparam int unsigned BMW      = SOFT_W + 1;
    localparam int unsigned INIT_BIG = 1 << (METRIC_W - 2);

    typedef logic [METRIC_W-1:0] met_t;
    typedef met_t [NS-1:0]       mvec_t;

    typedef struct packed {
        logic                 bv;
        logic [3:0][BMW-1:0]  bm;
        logic                 dv;
        logic [NS-1:0]        dec;
        mvec_t                met;
    } st_t;

    function automatic mvec_t start_metrics();
        mvec_t v;
        for (int i = 0; i < NS; i++) v[i] = (i == 0) ? '0 : met_t'(INIT_BIG);
        return v;
    endfunction

    st_t st_d, st_q;

    logic [3:0][BMW-1:0] bm_now;
    mvec_t               met_nx;
    logic [NS-1:0]       dec_nx;
    met_t                min_old;
    logic [SB-1:0]       best_idx;
    mvec_t               met_cur;

    acs_bm_unit #(.SOFT_W(SOFT_W)) u_bm (
        .soft_a (soft_a),
        .soft_b (soft_b),
        .bm     (bm_now)
    );

    acs_argmin #(.NS(NS), .MW(METRIC_W)) u_min (
        .met     (st_q.met),
        .min_val (min_old),
        .min_idx (best_idx)
    );

    for (genvar j = 0; j < HALF; j++) begin : g_bfly
        logic [1:0][METRIC_W-1:0] pair_m;
        logic [1:0]               pair_d;
        acs_bfly #(
            .J(j), .HALF(HALF), .POLY_A(POLY_A), .POLY_B(POLY_B),
            .BMW(BMW), .MW(METRIC_W)
        ) u_bf (
            .m_up    (st_q.met[j]),
            .m_lo    (st_q.met[j + HALF]),
            .bm      (st_q.bm),
            .min_old (min_old),
            .m_new   (pair_m),
            .dec     (pair_d)
        );
        assign met_nx[2*j]   = pair_m[0];
        assign met_nx[2*j+1] = pair_m[1];
        assign dec_nx[2*j]   = pair_d[0];
        assign dec_nx[2*j+1] = pair_d[1];
    end

    always_comb begin
        st_d    = st_q;
        st_d.bv = in_valid;
        st_d.bm = bm_now;
        st_d.dv = 1'b0;
        if (init) begin
            st_d.met = start_metrics();
        end else if (st_q.bv) begin
            st_d.met = met_nx;
            st_d.dec = dec_nx;
            st_d.dv  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bv  <= 1'b0;
            st_q.bm  <= '0;
            st_q.dv  <= 1'b0;
            st_q.dec <= '0;
            st_q.met <= start_metrics();
        end else begin
            st_q <= st_d;
        end
    end

    assign met_cur    = st_q.met;
    assign dec_valid  = st_q.dv;
    assign dec_word   = st_q.dec;
    assign best_state = best_idx;
endmodule

// File: rtl/acs_core_chk.sv
module acs_core_chk #(
    parameter int unsigned CONSTR   = 7,
    parameter int unsigned SOFT_W   = 4,
    parameter int unsigned METRIC_W = 9
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic                                      init,
    input logic                                      in_valid,
    input logic                                      dec_valid,
    input logic [(1<<(CONSTR-1))-1:0]                dec_word,
    input logic [CONSTR-2:0]                         best_state,
    input logic [(1<<(CONSTR-1))-1:0][METRIC_W-1:0]  met_cur
);
    localparam int unsigned NS      = 1 << (CONSTR - 1);
    localparam int unsigned CEILING = (1 << METRIC_W) - 1 - 2 * ((1 << SOFT_W) - 1);

    logic [METRIC_W-1:0] lo, hi;
    always_comb begin
        lo = met_cur[0];
        hi = met_cur[0];
        for (int i = 1; i < NS; i++) begin
            if (met_cur[i] < lo) lo = met_cur[i];
            if (met_cur[i] > hi) hi = met_cur[i];
        end
    end

    // R7: a valid pair yields a step two edges later unless init intervened
    a_r7_step_follows: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid, 2) && !$past(init) && !$past(rst) && !$past(rst, 2)) |-> dec_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid, 2) || $past(init)) |-> !dec_valid);

    // R6: outputs hold between steps
    a_r6_dec_hold: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid && !$past(rst)) |-> $stable(dec_word));

    a_r6_best_hold: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid && !$past(rst) && !$past(init)) |-> $stable(best_state));

    // R8: after init the best state is state 0
    a_r8_init_best: assert property (@(posedge clk) disable iff (rst)
        ($past(init) && !$past(rst)) |-> (best_state == '0));

    // R5: best state carries a minimal metric
    a_r5_best_is_min: assert property (@(posedge clk) disable iff (rst)
        met_cur[best_state] == lo);

    // R4: renormalization keeps metrics clear of the ceiling
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        hi <= METRIC_W'(CEILING));
endmodule

bind acs_core acs_core_chk #(
    .CONSTR(CONSTR), .SOFT_W(SOFT_W), .METRIC_W(METRIC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init       (init),
    .in_valid   (in_valid),
    .dec_valid  (dec_valid),
    .dec_word   (dec_word),
    .best_state (best_state),
    .met_cur    (met_cur)
);

// File: tb/acs_core_bench.sv
module acs_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  soft_a = '0;
    logic [3:0]  soft_b = '0;
    logic        dec_valid;
    logic [63:0] dec_word;
    logic [5:0]  best_state;

    acs_core u_acs_core (
        .clk(clk), .rst(rst), .init(init), .in_valid(in_valid),
        .soft_a(soft_a), .soft_b(soft_b),
        .dec_valid(dec_valid), .dec_word(dec_word), .best_state(best_state)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [63:0] dec;
        int          best;
        int          trk;
    } item_t;

    item_t sbq[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    last_v = 0;
    int    m[64];
    int    enc_st = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input int p, input int u);
        int w, a, b;
        w = (p << 1) | u;
        a = $countones(w & 7'o133) % 2;
        b = $countones(w & 7'o171) % 2;
        return a * 2 + b;
    endfunction

    function automatic int bm_of(input int sa, input int sb, input int c);
        int da, db;
        da = ((c >> 1) & 1) ? 15 - sa : sa;
        db = (c & 1) ? 15 - sb : sb;
        return da + db;
    endfunction

    task automatic model_init();
        for (int i = 0; i < 64; i++) m[i] = (i == 0) ? 0 : 128;
    endtask

    task automatic model_step(input int sa, input int sb, output logic [63:0] d, output int best);
        int nm[64];
        int mn, c0, c1;
        mn = m[0];
        for (int i = 1; i < 64; i++) if (m[i] < mn) mn = m[i];
        for (int n = 0; n < 64; n++) begin
            c0 = m[n >> 1] + bm_of(sa, sb, code_of(n >> 1, n & 1));
            c1 = m[(n >> 1) + 32] + bm_of(sa, sb, code_of((n >> 1) + 32, n & 1));
            d[n] = (c1 < c0);
            nm[n] = ((c1 < c0) ? c1 : c0) - mn;
        end
        best = 0;
        for (int n = 0; n < 64; n++) begin
            m[n] = nm[n];
            if (nm[n] < nm[best]) best = n;
        end
    endtask

    task automatic drive(input int sa, input int sb, input bit ini, input int trk);
        item_t it;
        @(negedge clk);
        if (ini) begin
            if (last_v) void'(sbq.pop_back());
            model_init();
        end
        model_step(sa, sb, it.dec, it.best);
        it.trk = trk;
        sbq.push_back(it);
        soft_a = 4'(sa);
        soft_b = 4'(sb);
        in_valid = 1'b1;
        init = ini;
        last_v = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            init = 1'b0;
            last_v = 1'b0;
        end
    endtask

    // noise-free encoded bit, full confidence
    task automatic send_clean(input int u, input bit ini);
        int w, a, b;
        if (ini) enc_st = 0;
        w = (enc_st << 1) | u;
        a = $countones(w & 7'o133) % 2;
        b = $countones(w & 7'o171) % 2;
        enc_st = w & 63;
        drive(a ? 15 : 0, b ? 15 : 0, ini, enc_st);
    endtask

    // monitor / scoreboard
    logic        init_at_edge = 1'b0;
    logic [63:0] prev_dec = '0;
    logic [5:0]  prev_best = '0;
    always @(posedge clk) init_at_edge <= init;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (dec_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected step", 64'(dec_valid), 64'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(dec_word === it.dec, "R3", "decision word", dec_word, it.dec);
                    chk(best_state === 6'(it.best), "R5", "best state", 64'(best_state), 64'(it.best));
                    if (it.trk >= 0)
                        chk(best_state === 6'(it.trk), "R10", "tracks encoder", 64'(best_state), 64'(it.trk));
                end
            end else begin
                chk(dec_word === prev_dec, "R6", "decision held", dec_word, prev_dec);
                if (!init_at_edge)
                    chk(best_state === prev_best, "R6", "best held", 64'(best_state), 64'(prev_best));
            end
        end
        prev_dec  = dec_word;
        prev_best = best_state;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(dec_valid === 1'b0, "R9", "dec_valid after reset", 64'(dec_valid), 64'd0);
        chk(dec_word === '0, "R9", "dec_word after reset", dec_word, 64'd0);
        chk(best_state === '0, "R9", "best after reset", 64'(best_state), 64'd0);
        rst = 1'b0;
        idle(2);

        // R10/R2/R3: noise-free message from init
        send_clean(1, 1'b1);
        for (int i = 0; i < 60; i++) send_clean(int'($urandom_range(0, 1)), 1'b0);

        // R7: gaps in valid
        idle(3);
        for (int i = 0; i < 20; i++) begin
            send_clean(int'($urandom_range(0, 1)), 1'b0);
            if (i % 4 == 3) idle(1);
        end
        idle(3);

        // R7: exact latency of a single step
        drive(3, 12, 1'b0, -1);
        @(negedge clk);
        in_valid = 1'b0;
        last_v = 1'b0;
        chk(dec_valid === 1'b0, "R7", "one edge after input", 64'(dec_valid), 64'd0);
        @(negedge clk);
        chk(dec_valid === 1'b1, "R7", "two edges after input", 64'(dec_valid), 64'd1);
        idle(2);

        // R1/R4: noisy and full-scale random soft values, long run
        for (int i = 0; i < 300; i++)
            drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 1'b0, -1);
        // R4: worst-case alternating extremes
        for (int i = 0; i < 100; i++)
            drive((i % 2) ? 15 : 0, (i % 3) ? 0 : 15, 1'b0, -1);

        // R3: near-erasure values produce many ties
        for (int i = 0; i < 40; i++)
            drive(7 + (i % 2), 8 - (i % 2), 1'b0, -1);

        // R8: init while a step is in flight drops that step
        drive(2, 13, 1'b0, -1);
        send_clean(0, 1'b1);
        for (int i = 0; i < 30; i++) send_clean(int'($urandom_range(0, 1)), 1'b0);
        idle(3);

        // R8: init alone restarts at state 0
        @(negedge clk);
        init = 1'b1;
        in_valid = 1'b0;
        model_init();
        @(negedge clk);
        init = 1'b0;
        chk(best_state === '0, "R8", "best after init", 64'(best_state), 64'd0);
        enc_st = 0;
        for (int i = 0; i < 20; i++) send_clean(int'($urandom_range(0, 1)), 1'b0);
        idle(3);

        // R9: reset in the middle of operation
        for (int i = 0; i < 10; i++)
            drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 1'b0, -1);
        idle(3);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(dec_valid === 1'b0, "R9", "dec_valid after second reset", 64'(dec_valid), 64'd0);
        chk(dec_word === '0, "R9", "dec_word after second reset", dec_word, 64'd0);
        chk(best_state === '0, "R9", "best after second reset", 64'(best_state), 64'd0);
        rst = 1'b0;
        model_init();
        enc_st = 0;
        for (int i = 0; i < 15; i++) send_clean(int'($urandom_range(0, 1)), 1'b0);
        idle(4);

        chk(sbq.size() == 0, "R7", "all steps delivered", 64'(sbq.size()), 64'd0);
        finish_run();
    end
endmodule